// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit holds the program counter of a 16-bit processor and decides, one instruction at a time, where execution goes next. Each cycle it receives the instruction word being executed and the two register values the decoder read for it. The first value comes from the register named in bits [8:6] and the second from the register named in bits [11:9]. From these it produces the next program counter, a link write (enable and value) for jump-and-link forms, a one-cycle system-call request carrying the service number, and a flag for a register-jump target that is not word aligned.

The program counter advances only when `step_en` is high. While it is low the outputs still show the resolved target, but every side-effect output (link write, trap request, misalignment) stays low. All address arithmetic wraps modulo 2^16. Instruction fetch, the trap entry sequence and the register file are outside this block.

Top module: `nxpc_unit`

## Requirements
- R1: After reset is released, `pc_q` reads 0x0000.
- R2: An instruction that is not a branch, jump or system call gives `next_pc = pc_q + 2`, wrapping 0xFFFE to 0x0000.
- R3: Opcode bits [2:0]=010 is a conditional branch. Bits [5:3] select the test of `opa` against `opb`: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. When the test holds, `next_pc = pc_q + sext({insn[15:12],0})`; otherwise it is `pc_q + 2`.
- R4: Branch selectors 010 (take if `opa` is zero) and 011 (take if `opa` is non-zero) give results that do not depend on `opb`.
- R5: Opcode 101 is an unconditional relative jump to `pc_q + sext({insn[14:9],insn[5:3],0})`. Bit 15 set marks the linking form.
- R6: The linking relative jump, and the register jump with bits [15:12]=1100, bits [5:3]=000 and opcode 000, raise `link_we` with `link_val = pc_q + 2`. No other instruction raises `link_we`.
- R7: Opcode 000 with bits [15:12]=1011 and bits [5:3]=000 jumps to `opa`. The linking register jump (1100) jumps to `opb`.
- R8: A register-jump target with bit 0 set raises `misalign`, and `next_pc` carries that target with bit 0 cleared.
- R9: Opcode 111 with bits [5:3]=000 raises `trap_req` for that step, with `trap_svc = insn[15:6]`, and `next_pc = pc_q + 2`.
- R10: While `step_en` is low, `pc_q` holds and `link_we`, `trap_req` and `misalign` stay low.
- R11: On a clock edge with `step_en` high, `pc_q` takes the value `next_pc` showed before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Retire the presented instruction this cycle |
| insn | input | 16 | Instruction word being executed |
| opa | input | 16 | Value of register named in bits [8:6] |
| opb | input | 16 | Value of register named in bits [11:9] |
| pc_q | output | 16 | Current program counter |
| next_pc | output | 16 | Resolved next program counter |
| link_we | output | 1 | Write the link value to the register in bits [8:6] |
| link_val | output | 16 | Return address, pc_q + 2 |
| trap_req | output | 1 | System-call request for this step |
| trap_svc | output | 10 | Service number of the system call |
| misalign | output | 1 | Register-jump target had bit 0 set |

## Verification
The assertions assume the program counter only ever holds even values. That in turn assumes every offset the block adds is even, and that register-jump targets are aligned before they are loaded. The bench keeps within this: the program counter is reached only through reset, relative offsets and register jumps, and every odd register target is one that the block itself must clear. The assertions also assume the operand values are stable across a step. The bench drives all inputs on the falling edge, so they are settled at the rising edge.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  localparam int ILEN = 16;
  localparam int SVCW = 10;

  localparam logic [2:0] OPC_REG  = 3'b000;
  localparam logic [2:0] OPC_BRN  = 3'b010;
  localparam logic [2:0] OPC_JMP  = 3'b101;
  localparam logic [2:0] OPC_SYS  = 3'b111;

  localparam logic [3:0] F4_JR    = 4'b1011;
  localparam logic [3:0] F4_JALR  = 4'b1100;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BRN,
    FLOW_JMP,
    FLOW_RJA,
    FLOW_RJB,
    FLOW_SYS
  } flow_e;

  typedef struct packed {
    flow_e      kind;
    logic       link;
    logic [2:0] cond;
  } ctl_t;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
  import nxpc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [ILEN-1:0] insn,
  output ctl_t            ctl,
  output logic [XLEN-1:0] boff,
  output logic [XLEN-1:0] joff,
  output logic [SVCW-1:0] svc
);

  localparam int BW = 5;
  localparam int JW = 10;

  logic [2:0] opc;
  logic [2:0] f3;
  logic [3:0] f4;

  assign opc = insn[2:0];
  assign f3  = insn[5:3];
  assign f4  = insn[15:12];

  always_comb begin
    ctl.kind = FLOW_SEQ;
    ctl.link = 1'b0;
    ctl.cond = f3;
    unique case (opc)
      OPC_REG: begin
        if (f3 == 3'b000 && f4 == F4_JR) begin
          ctl.kind = FLOW_RJA;
        end else if (f3 == 3'b000 && f4 == F4_JALR) begin
          ctl.kind = FLOW_RJB;
          ctl.link = 1'b1;
        end
      end
      OPC_BRN: ctl.kind = FLOW_BRN;
      OPC_JMP: begin
        ctl.kind = FLOW_JMP;
        ctl.link = insn[15];
      end
      OPC_SYS: begin
        if (f3 == 3'b000) ctl.kind = FLOW_SYS;
      end
      default: ctl.kind = FLOW_SEQ;
    endcase
  end

  assign boff = {{(XLEN-BW){insn[15]}}, insn[15:12], 1'b0};
  assign joff = {{(XLEN-JW){insn[14]}}, insn[14:9], insn[5:3], 1'b0};
  assign svc  = insn[15:6];

endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      sel,
  output logic            take
);

  localparam int NCOND = 8;

  logic [NCOND-1:0] hit;
  logic             eq;
  logic             zr;
  logic             lts;
  logic             ltu;

  assign eq  = (a == b);
  assign zr  = (a == '0);
  assign lts = ($signed(a) < $signed(b));
  assign ltu = (a < b);

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    if (i == 0)      begin : g_eq  assign hit[i] = eq;   end
    else if (i == 1) begin : g_ne  assign hit[i] = !eq;  end
    else if (i == 2) begin : g_z   assign hit[i] = zr;   end
    else if (i == 3) begin : g_nz  assign hit[i] = !zr;  end
    else if (i == 4) begin : g_lt  assign hit[i] = lts;  end
    else if (i == 5) begin : g_ge  assign hit[i] = !lts; end
    else if (i == 6) begin : g_ltu assign hit[i] = ltu;  end
    else             begin : g_geu assign hit[i] = !ltu; end
  end

  assign take = hit[sel];

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
  import nxpc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] pc,
  input  ctl_t            ctl,
  input  logic            take,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] boff,
  input  logic [XLEN-1:0] joff,
  output logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] link,
  output logic            odd
);

  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] rel_off;
  logic [XLEN-1:0] reg_tgt;
  logic            use_rel;

  assign seq_pc  = pc + STEP;
  assign rel_off = (ctl.kind == FLOW_JMP) ? joff : boff;
  assign rel_pc  = pc + rel_off;
  assign reg_tgt = (ctl.kind == FLOW_RJB) ? b : a;
  assign use_rel = (ctl.kind == FLOW_JMP) || ((ctl.kind == FLOW_BRN) && take);

  always_comb begin
    npc = seq_pc;
    odd = 1'b0;
    if (ctl.kind == FLOW_RJA || ctl.kind == FLOW_RJB) begin
      npc = {reg_tgt[XLEN-1:1], 1'b0};
      odd = reg_tgt[0];
    end else if (use_rel) begin
      npc = rel_pc;
    end
  end

  assign link = seq_pc;

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int               XLEN     = 16,
  parameter logic [XLEN-1:0]  RST_VEC  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [15:0]      insn,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  next_pc,
  output logic             link_we,
  output logic [XLEN-1:0]  link_val,
  output logic             trap_req,
  output logic [SVCW-1:0]  trap_svc,
  output logic             misalign
);

  ctl_t            ctl;
  logic [XLEN-1:0] boff;
  logic [XLEN-1:0] joff;
  logic            take;
  logic            odd;
  logic [XLEN-1:0] pc_d;

  nxpc_decode #(.XLEN(XLEN)) u_dec (
    .insn (insn),
    .ctl  (ctl),
    .boff (boff),
    .joff (joff),
    .svc  (trap_svc)
  );

  nxpc_cond #(.XLEN(XLEN)) u_cond (
    .a    (opa),
    .b    (opb),
    .sel  (ctl.cond),
    .take (take)
  );

  nxpc_target #(.XLEN(XLEN)) u_tgt (
    .pc   (pc_q),
    .ctl  (ctl),
    .take (take),
    .a    (opa),
    .b    (opb),
    .boff (boff),
    .joff (joff),
    .npc  (next_pc),
    .link (link_val),
    .odd  (odd)
  );

  assign link_we  = step_en && ctl.link;
  assign trap_req = step_en && (ctl.kind == FLOW_SYS);
  assign misalign = step_en && odd;

  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_VEC;
    else        pc_q <= pc_d;
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc_q == $past(next_pc));

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> !(link_we || trap_req || misalign));

  // R8
  even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[0] == 1'b0);

  // R9
  trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (next_pc == pc_q + XLEN'(2)) && !link_we);

  // R6
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_val == pc_q + XLEN'(2));

endmodule

// File: tb/sim_nxpc_unit.sv
module sim_nxpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [15:0] insn = 16'h0;
  logic [15:0] opa = 16'h0;
  logic [15:0] opb = 16'h0;
  logic [15:0] pc_q, next_pc, link_val;
  logic        link_we, trap_req, misalign;
  logic [9:0]  trap_svc;

  int checks = 0;
  int fails  = 0;
  int mpc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nxpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .insn(insn),
    .opa(opa), .opb(opb), .pc_q(pc_q), .next_pc(next_pc),
    .link_we(link_we), .link_val(link_val), .trap_req(trap_req),
    .trap_svc(trap_svc), .misalign(misalign)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  // Behavioural model: one step from (pc, instruction, operands).
  task automatic model(input int pc, input int w, input int a, input int b, input bit en,
                       output int np, output bit lw, output int lv, output bit tr,
                       output int sv, output bit mis);
    int opc = w & 7;
    int f3  = (w >> 3) & 7;
    int f4  = (w >> 12) & 15;
    int tgt = pc + 2;
    bit tk;
    lw = 0; tr = 0; mis = 0;
    lv = (pc + 2) & 16'hFFFF;
    sv = (w >> 6) & 10'h3FF;
    if (opc == 0 && f3 == 0 && f4 == 11) begin
      tgt = a; mis = a & 1;
    end else if (opc == 0 && f3 == 0 && f4 == 12) begin
      tgt = b; mis = b & 1; lw = 1;
    end else if (opc == 2) begin
      case (f3)
        0: tk = (a == b);
        1: tk = (a != b);
        2: tk = (a == 0);
        3: tk = (a != 0);
        4: tk = sgn(a) < sgn(b);
        5: tk = sgn(a) >= sgn(b);
        6: tk = a < b;
        default: tk = a >= b;
      endcase
      if (tk) tgt = pc + sx(((w >> 12) & 15) * 2, 5);
    end else if (opc == 5) begin
      tgt = pc + sx((((w >> 9) & 63) << 4) | (((w >> 3) & 7) << 1), 10);
      lw = (w >> 15) & 1;
    end else if (opc == 7 && f3 == 0) begin
      tr = 1;
    end
    np = tgt & 16'hFFFE;
    if (!en) begin lw = 0; tr = 0; mis = 0; end
  endtask

  task automatic step(input string tag, input logic [15:0] w, input logic [15:0] a,
                      input logic [15:0] b, input bit en);
    int np, lv, sv;
    bit lw, tr, mis;
    @(negedge clk);
    insn = w; opa = a; opb = b; step_en = en;
    #1;
    model(mpc, w, a, b, en, np, lw, lv, tr, sv, mis);
    check(tag, "pc_q", pc_q, mpc);
    check(tag, "next_pc", next_pc, np);
    check(tag, "link_we", link_we, lw);
    if (lw) check(tag, "link_val", link_val, lv);
    check(tag, "trap_req", trap_req, tr);
    if (tr) check(tag, "trap_svc", trap_svc, sv);
    check(tag, "misalign", misalign, mis);
    @(posedge clk);
    if (en) mpc = np;
  endtask

  function automatic logic [15:0] br(input int f3, input int off);
    logic [4:0] o = 5'(off);
    return {o[4:1], 3'd0, 3'd0, 3'(f3), 3'b010};
  endfunction

  function automatic logic [15:0] jmp(input bit l, input int off);
    logic [9:0] o = 10'(off);
    return {l, o[9:4], 3'd0, o[3:1], 3'b101};
  endfunction

  localparam logic [15:0] JR_W   = 16'hB000;
  localparam logic [15:0] JALR_W = 16'hC000;
  localparam logic [15:0] ADDI_W = 16'h0049;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset pc", pc_q, 0);

    step("R2", ADDI_W, 16'h1234, 16'h5678, 1);
    step("R2", 16'h0000, 16'h0001, 16'h0002, 1);
    step("R10", ADDI_W, 0, 0, 0);
    step("R10", jmp(1, 40), 0, 0, 0);
    step("R10", 16'h0107, 0, 0, 0);
    step("R7", JR_W, 16'h0100, 16'h0EEE, 1);
    step("R11", ADDI_W, 0, 0, 1);
    // R3 each selector taken and not taken
    step("R3", br(0, 6), 16'h55AA, 16'h55AA, 1);
    step("R3", br(0, 6), 16'h55AA, 16'h55AB, 1);
    step("R3", br(1, -4), 16'h0001, 16'h0002, 1);
    step("R3", br(1, -4), 16'h0003, 16'h0003, 1);
    step("R3", br(4, 14), 16'h8000, 16'h0001, 1);
    step("R3", br(4, 14), 16'h0001, 16'h8000, 1);
    step("R3", br(5, -16), 16'h7FFF, 16'hFFFF, 1);
    step("R3", br(5, -16), 16'hFFFE, 16'hFFFF, 1);
    step("R3", br(6, 2), 16'h0001, 16'h8000, 1);
    step("R3", br(6, 2), 16'h8000, 16'h0001, 1);
    step("R3", br(7, 8), 16'hFFFF, 16'hFFFF, 1);
    step("R3", br(7, 8), 16'h0000, 16'h0001, 1);
    // R4 zero tests with varied opb
    step("R4", br(2, 10), 16'h0000, 16'hFFFF, 1);
    step("R4", br(2, 10), 16'h0000, 16'h0000, 1);
    step("R4", br(2, 10), 16'h0400, 16'h0400, 1);
    step("R4", br(3, -8), 16'h0400, 16'h0000, 1);
    step("R4", br(3, -8), 16'h0000, 16'h1234, 1);
    // R5 jumps
    step("R5", jmp(0, 1022), 0, 0, 1);
    step("R5", jmp(0, -1024), 0, 0, 1);
    step("R6", jmp(1, -2), 0, 0, 1);
    step("R6", jmp(1, 36), 0, 0, 1);
    step("R6", JALR_W, 16'h7777, 16'h2000, 1);
    step("R7", JR_W, 16'h3000, 16'h4445, 1);
    // R8 odd register targets
    step("R8", JR_W, 16'h1235, 16'h0000, 1);
    step("R8", JALR_W, 16'h0000, 16'hABCF, 1);
    step("R8", JALR_W, 16'h0001, 16'h0010, 0);
    // R9 system call
    step("R9", 16'hFFC7, 0, 0, 1);
    step("R9", 16'h0147, 16'h5555, 16'hAAAA, 1);
    step("R9", 16'h0157, 0, 0, 1);
    step("R10", 16'hFFC7, 0, 0, 0);
    // R2 wrap at top of space
    step("R7", JR_W, 16'hFFFE, 0, 1);
    step("R2", ADDI_W, 0, 0, 1);
    step("R3", br(0, -16), 16'h0001, 16'h0001, 1);
    step("R11", ADDI_W, 0, 0, 1);
    step("R3", br(3, 14), 16'h0001, 0, 1);
    step("R11", 16'h0000, 0, 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule